// File: doc/BRIEF.md
# Half-Band Interpolate-by-Two Filter

This block doubles the sample rate of a fixed-point stream using a half-band FIR response. For every accepted input sample it emits two output samples: an even-phase sample from the folded symmetric branch and an odd-phase sample from the centre-tap branch. Every other coefficient of a half-band response is zero, so those taps are never fetched or multiplied. The centre coefficient is one half, which reduces that branch to a delayed input shifted right by one bit. The remaining non-zero taps come in equal pairs, so each pair of history samples is added before a single multiply.

The parameter `II` names the number of clock cycles the block may spend on each input. It sets the number of parallel multiply lanes to `LANES = ceil(NU/II)`, where `NU = (TAPS+1)/4` is the number of unique folded coefficients. A finished input then takes `STEPS = ceil(NU/LANES)` cycles to compute. One design therefore serves each stage of a cascade, with a large `II` early in the chain and `II = 2` at the full-rate end. Complex data is handled with one instance per rail.

Both the input and the output use valid/ready handshakes. A transfer takes place on a rising clock edge where valid and ready are both high. The output may be stalled indefinitely. While it is stalled, the output sample is held. Once a computed pair has no room in the two-entry output stage, the input side stops accepting samples. No sample is dropped or duplicated.

Top module: `hb_interp2`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and every history sample reads as zero.
- R2: Each accepted input yields exactly two outputs. The even-phase sample comes first, then the odd-phase sample. Pairs leave in the order their inputs were accepted, and none is lost or repeated under any pattern of `in_valid` and `out_ready`.
- R3: Let x[n] be the newest accepted sample and NT = (TAPS+1)/2. The even-phase output is sum over i < NU of c_i·(x[n-i] + x[n-(NT-1)+i]). Coefficient c_i is the signed field `COEFS[i*COEF_W +: COEF_W]`, with COEF_W-1 fraction bits.
- R4: The odd-phase output is x[n-D]/2 with D = (TAPS-1)/4. It is formed by an arithmetic shift, with no multiplier.
- R5: Both outputs round to nearest, with ties toward plus infinity: half an LSB is added and the result is floored. The even-phase output then saturates to the range -2^(DW-1) .. 2^(DW-1)-1.
- R6: The NU multiplies of one input run on LANES = ceil(NU/II) multipliers over STEPS = ceil(NU/LANES) cycles. While the output stage can take the result, `in_ready` stays low for exactly STEPS-1 cycles after each accepting edge.
- R7: When the output stage is empty, `out_valid` rises exactly STEPS clock edges after the edge that accepted the input. It carries the even-phase sample of that input.
- R8: With `II = 2`, `in_valid` held high and `out_ready` held high, `out_valid` is high on every cycle once the first pair is out.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values. A computed pair waits, with `in_ready` low, until both output slots are free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can accept a sample on this edge |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Output sample available |
| out_ready | input | 1 | Consumer takes the output on this edge |
| out_data | output | DW | Signed output sample, even phase then odd phase |

## Verification
An accepted sample occupies the fold engine for STEPS edges. Its even-phase result appears on the output after the STEPS-th edge, and the odd-phase result follows one accepted output transfer later. The bench never waits a fixed number of cycles for data. It samples every handshake half a period after the edge and matches each output transfer against a queue of values computed from its own copy of the history. The latency check and the ready-gap check are the exceptions: they look at fixed negedges right after an accept from idle, counted as STEPS edges for `out_valid` and STEPS-1 cycles for the `in_ready` gap.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // integer ceiling division used to size the folded MAC
  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int min_one(input int a);
    return (a < 1) ? 1 : a;
  endfunction

endpackage

// File: rtl/hb_tap_line.sv
module hb_tap_line #(
  parameter int DW = 16,
  parameter int NT = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift,
  input  logic [DW-1:0]          din,
  output logic [NT-1:0][DW-1:0]  taps
);

  // taps[0] holds the newest sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps <= '0;
    end else if (shift) begin
      taps <= {taps[NT-2:0], din};
    end
  end

endmodule

// File: rtl/hb_fold_mac.sv
module hb_fold_mac #(
  parameter int DW    = 16,
  parameter int CW    = 18,
  parameter int NT    = 12,
  parameter int NU    = 6,
  parameter int LANES = 2,
  parameter int STEPS = 3,
  parameter int SW    = 2,
  parameter int AW    = 40,
  parameter logic [NU*CW-1:0] COEFS = '0
) (
  input  logic [NT-1:0][DW-1:0] taps,
  input  logic [SW-1:0]         step,
  output logic signed [AW-1:0]  part
);

  localparam int PW = DW + CW + 1;

  logic signed [DW:0]   pair_sum [NU];
  logic signed [CW-1:0] coef_w   [NU];
  logic signed [PW-1:0] prod     [LANES];

  // fold each symmetric pair before it reaches a multiplier
  for (genvar p = 0; p < NU; p++) begin : g_pair
    assign pair_sum[p] = $signed({taps[p][DW-1], taps[p]})
                       + $signed({taps[NT-1-p][DW-1], taps[NT-1-p]});
    assign coef_w[p]   = $signed(COEFS[p*CW +: CW]);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [DW:0]   opnd;
    logic signed [CW-1:0] cf;
    always_comb begin
      opnd = '0;
      cf   = '0;
      for (int s = 0; s < STEPS; s++) begin
        int k;
        k = s * LANES + l;
        if (step == SW'(s) && k < NU) begin
          opnd = pair_sum[k];
          cf   = coef_w[k];
        end
      end
    end
    assign prod[l] = opnd * cf;
  end

  always_comb begin
    part = '0;
    for (int l = 0; l < LANES; l++) begin
      part = part + {{(AW-PW){prod[l][PW-1]}}, prod[l]};
    end
  end

endmodule

// File: rtl/hb_pair_buf.sv
module hb_pair_buf #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] even_d,
  input  logic [DW-1:0] odd_d,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          can_load
);

  logic [1:0]    cnt;
  logic [DW-1:0] slot0, slot1;
  logic          pop;

  assign out_valid = (cnt != 2'd0);
  assign out_data  = slot0;
  assign pop       = out_valid & out_ready;
  assign can_load  = (cnt == 2'd0) | ((cnt == 2'd1) & out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= 2'd0;
      slot0 <= '0;
      slot1 <= '0;
    end else if (load) begin
      slot0 <= even_d;
      slot1 <= odd_d;
      cnt   <= 2'd2;
    end else if (pop) begin
      slot0 <= slot1;
      cnt   <= cnt - 2'd1;
    end
  end

endmodule

// File: rtl/hb_interp2.sv
module hb_interp2 #(
  parameter int DW    = 16,
  parameter int CW    = 18,
  parameter int TAPS  = 23,
  parameter int II    = 4,
  parameter logic [((TAPS+1)/4)*CW-1:0] COEFS =
    {18'h06A02, 18'h01FD6, 18'h3F18C, 18'h00672, 18'h3FD94, 18'h00096}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);

  localparam int NT    = (TAPS + 1) / 2;
  localparam int NU    = (TAPS + 1) / 4;
  localparam int DLY   = (TAPS - 1) / 4;
  localparam int LANES = hb_pkg::ceil_div(NU, II);
  localparam int STEPS = hb_pkg::ceil_div(NU, LANES);
  localparam int SW    = hb_pkg::min_one($clog2(STEPS));
  localparam int FRAC  = CW - 1;
  localparam int AW    = DW + CW + 2 + $clog2(NU + 1);
  localparam int QW    = AW - FRAC;

  localparam logic signed [AW-1:0] HALF = AW'(64'd1 << (FRAC - 1));
  localparam logic signed [QW-1:0] QMAX = {{(QW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [QW-1:0] QMIN = {{(QW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic [NT-1:0][DW-1:0] taps;
  logic                  busy;
  logic [SW-1:0]         step;
  logic                  last, finish, advance, in_fire, can_load;
  logic signed [AW-1:0]  part, acc_q, acc_nx, rnd;
  logic signed [QW-1:0]  q;
  logic [DW-1:0]         even_res, odd_res;
  logic signed [DW:0]    odd_rnd;

  hb_tap_line #(.DW(DW), .NT(NT)) u_line (
    .clk(clk), .rst_n(rst_n), .shift(in_fire), .din(in_data), .taps(taps)
  );

  hb_fold_mac #(
    .DW(DW), .CW(CW), .NT(NT), .NU(NU), .LANES(LANES), .STEPS(STEPS),
    .SW(SW), .AW(AW), .COEFS(COEFS)
  ) u_mac (
    .taps(taps), .step(step), .part(part)
  );

  hb_pair_buf #(.DW(DW)) u_obuf (
    .clk(clk), .rst_n(rst_n), .load(finish), .even_d(even_res),
    .odd_d(odd_res), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .can_load(can_load)
  );

  // sequencing: the last fold step retires only if the pair fits
  assign last     = (step == SW'(STEPS - 1));
  assign finish   = busy & last & can_load;
  assign advance  = busy & ~last;
  assign in_ready = ~busy | finish;
  assign in_fire  = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
    end else if (in_fire) begin
      busy <= 1'b1;
      step <= '0;
    end else if (finish) begin
      busy <= 1'b0;
    end else if (advance) begin
      step <= step + SW'(1);
    end
  end

  assign acc_nx = acc_q + part;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (in_fire) begin
      acc_q <= '0;
    end else if (advance) begin
      acc_q <= acc_nx;
    end
  end

  // even phase: round half up, then clamp to the output range
  always_comb begin
    rnd = acc_nx + HALF;
    q   = rnd[AW-1:FRAC];
    if (q > QMAX)      even_res = QMAX[DW-1:0];
    else if (q < QMIN) even_res = QMIN[DW-1:0];
    else               even_res = q[DW-1:0];
  end

  // odd phase: centre tap of one half is a rounded shift
  assign odd_rnd = $signed({taps[DLY][DW-1], taps[DLY]}) + $signed((DW+1)'(1));
  assign odd_res = odd_rnd[DW:1];

endmodule

// File: rtl/hb_interp2_chk.sv
module hb_interp2_chk #(
  parameter int DW    = 16,
  parameter int STEPS = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data
);

  // R9
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (STEPS > 1)) |=> !in_ready);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  // R2
  known_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(out_data));

endmodule

bind hb_interp2 hb_interp2_chk #(.DW(DW), .STEPS(STEPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/hb_interp2_tb.sv
module hb_interp2_tb;

  localparam int DW   = 12;
  localparam int CW   = 18;
  localparam int TAPS = 23;
  localparam int NT   = 12;
  localparam int NU   = 6;
  localparam int DLY  = 5;
  localparam int STEPS_EXP = 2;  // II=2 -> 3 lanes, 2 steps
  localparam logic [NU*CW-1:0] TB_COEFS =
    {18'h15F90, 18'h01FD6, 18'h3F18C, 18'h00672, 18'h3FD94, 18'h00096};
  localparam int COEF [NU] = '{150, -620, 1650, -3700, 8150, 90000};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int hist [NT];
  int expq [$];
  string tagq [$];
  int n_in = 0;
  int n_out = 0;
  bit prev_stall = 1'b0;
  logic [DW-1:0] prev_data = '0;
  bit watch = 1'b0;
  int gaps = 0;
  int lfsr = 32'h1ACE5;

  always #10 clk = ~clk;  // 50 MHz

  hb_interp2 #(.DW(DW), .CW(CW), .TAPS(TAPS), .II(2), .COEFS(TB_COEFS)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input longint v);
    longint r;
    r = (v + 65536) >>> 17;
    if (r > 2047) return 2047;
    if (r < -2048) return -2048;
    return int'(r);
  endfunction

  task automatic model_push(input int d);
    longint s;
    for (int i = NT - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = d;
    s = 0;
    for (int i = 0; i < NU; i++) s += longint'(COEF[i]) * (hist[i] + hist[NT-1-i]);
    expq.push_back(sat(s));
    tagq.push_back("R3/R5 even");
    expq.push_back((hist[DLY] + 1) >>> 1);
    tagq.push_back("R4 odd");
    n_in++;
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(input bit v, input int d, input bit rdy, output bit fired);
    int e;
    string t;
    in_valid  = v;
    in_data   = d[DW-1:0];
    out_ready = rdy;
    #1;
    if (prev_stall)
      chk(out_valid && out_data == prev_data, "R9 hold",
          int'($signed(out_data)), int'($signed(prev_data)));
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    if (watch && !out_valid) gaps++;
    fired = in_valid && in_ready;
    if (fired) model_push(d);
    if (out_valid && out_ready) begin
      n_out++;
      if (expq.size() == 0) begin
        chk(1'b0, "R2 extra output", n_out, 2 * n_in);
      end else begin
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(int'($signed(out_data)) == e, t, int'($signed(out_data)), e);
      end
    end
    @(negedge clk);
  endtask

  task automatic send(input int d);
    bit f;
    f = 1'b0;
    while (!f) step(1'b1, d, 1'b1, f);
  endtask

  task automatic idle(input int n);
    bit f;
    for (int i = 0; i < n; i++) step(1'b0, 0, 1'b1, f);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_out, 2 * n_in);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit f;
    for (int i = 0; i < NT; i++) hist[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: idle after reset
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

    // R7 / R6: latency and ready gap from idle
    step(1'b1, 100, 1'b1, f);
    chk(f, "R1 first accept", int'(f), 1);
    out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R6 gap after accept", int'(in_ready), 0);
    chk(out_valid == 1'b0, "R7 not yet valid", int'(out_valid), 0);
    step(1'b0, 0, 1'b1, f);
    chk(in_ready == 1'b1, "R6 ready after STEPS-1", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R7 edge 1", int'(out_valid), 0);
    step(1'b0, 0, 1'b1, f);
    chk(out_valid == 1'b1, "R7 valid after STEPS edges", int'(out_valid), 1);
    idle(6);

    // R3 / R4: impulses through every history position
    send(1000);  idle(1);
    for (int i = 0; i < 13; i++) send(0);
    send(-1537);
    for (int i = 0; i < 13; i++) send(0);
    send(-3); send(3); send(-1); send(1);

    // R5: saturation both ways with full-scale plateaus
    for (int i = 0; i < 14; i++) send(2047);
    for (int i = 0; i < 14; i++) send(-2048);
    for (int i = 0; i < 14; i++) send(0);

    // exhaustive ramp over every input code, R8 throughput watched
    for (int v = -2048; v < 2048; v++) begin
      if (v == -2044) watch = 1'b1;
      send(v);
    end
    watch = 1'b0;
    chk(gaps == 0, "R8 output every cycle", gaps, 0);

    // R9 / R2: random stalls on both sides
    for (int i = 0; i < 600; i++) begin
      int d;
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >>> 17);
      lfsr = lfsr ^ (lfsr << 5);
      d = (lfsr >>> 4) % 2048;
      step(lfsr[1] | lfsr[2], d, lfsr[3] | lfsr[5], f);
    end
    // long stall with a full output stage
    for (int i = 0; i < 8; i++) step(1'b1, 77, 1'b0, f);
    chk(in_ready == 1'b0, "R9 input held off", int'(in_ready), 0);
    idle(12);

    chk(expq.size() == 0, "R2 all pairs drained", expq.size(), 0);
    chk(n_out == 2 * n_in, "R2 two outputs per input", n_out, 2 * n_in);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule